// File: doc/BRIEF.md
# Binary32 Floating-Point Multiplier

This block multiplies two IEEE 754 single-precision numbers and returns the product rounded to nearest, ties to even. Each operand's significand, with its hidden leading one put back, is held in a 32-bit word with three integer bits and twenty-nine fraction bits. The two words are multiplied into a 64-bit product. Every bit of the lower half of that product is collapsed into one sticky bit. The upper half is then shifted left until its leading one sits in the units position, and the shift count is folded into the exponent.

Operands arrive on a valid/ready handshake and the result leaves on a second one. The result is registered, and each accepted pair produces exactly one result, in order. Operands whose exponent field is all zeros or all ones are not computed. They are reported on a separate flag, and the result word is then zero. Results too large for the format become a signed infinity. Results whose exponent would be zero or negative become a signed zero.

Top module: `fmul_sp32`

## Requirements
- R1: The exponent of each operand is bits 30:23. If either exponent is 0 or 255, `out_special` is 1 and `out_result` is 0x00000000.
- R2: The sign bit (bit 31) of every non-special result is the XOR of the operand sign bits, including saturated and flushed results.
- R3: For normal operands whose product is in range, `out_result` equals the exact real product rounded to nearest with ties to even. The 23-bit fraction is in bits 22:0 and the biased exponent is in bits 30:23.
- R4: When the exact product lies exactly halfway between two neighbouring values, the value whose fraction LSB is 0 is returned.
- R5: When rounding carries out of an all-ones fraction, the fraction becomes 0 and the exponent rises by one.
- R6: If the exponent after rounding is 255 or more, the result is a signed infinity (exponent 255, fraction 0). A NaN pattern never appears on a non-special result.
- R7: If the exponent after rounding is 0 or less, the result is a signed zero. An exponent of exactly 1 is still returned as a normal number.
- R8: `in_ready` is high when the output register is empty or is being emptied in the same cycle. One result is produced per accepted operand pair, in acceptance order.
- R9: While `out_valid` is high and `out_ready` is low, `out_result` and `out_special` hold their values.
- R10: While reset is high, `out_valid` is driven to 0 on the next clock.
- R11: Product bits far below the rounding position still count for rounding: a product just above a halfway point rounds up even when its fraction LSB is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Operand pair can be taken this cycle |
| in_a | input | 32 | First binary32 operand |
| in_b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Rounded binary32 product, or zero when special |
| out_special | output | 1 | An operand had a reserved exponent (zero/subnormal/infinity/NaN) |

## Verification
The hardest situation to reach is a product whose rounding is decided only by bits that land in the discarded lower product word. Random operands almost never produce that, or an exact tie, or a rounding carry out of an all-ones fraction. The stimulus therefore includes operand pairs built by hand. One is (1+2^-23)×(1.5+2^-23), where a 2^-46 term alone breaks a tie. Another pair, whose integer significands multiply to 2^47−2, forces the carry. Overflow and underflow are reached with operands at the edges of the exponent range. All of this runs under random backpressure, so that results are also held against a stalled consumer.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  localparam int FMT_EXP_W = 8;
  localparam int FMT_MAN_W = 23;
  localparam int FMT_SIG_W = 32;
  localparam int FMT_Q_INT = 3;

  typedef enum logic [1:0] {
    RC_NORMAL  = 2'd0,
    RC_OVF     = 2'd1,
    RC_UNF     = 2'd2,
    RC_SPECIAL = 2'd3
  } res_class_e;
endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack #(
  parameter int EXP_W = fmul_pkg::FMT_EXP_W,
  parameter int MAN_W = fmul_pkg::FMT_MAN_W,
  parameter int SIG_W = fmul_pkg::FMT_SIG_W,
  parameter int Q_INT = fmul_pkg::FMT_Q_INT
) (
  input  logic [EXP_W+MAN_W:0] op,
  output logic                 sign,
  output logic [EXP_W-1:0]     expo,
  output logic [SIG_W-1:0]     sig,
  output logic                 reserved
);
  localparam int PAD = SIG_W - Q_INT - MAN_W;

  assign sign     = op[EXP_W+MAN_W];
  assign expo     = op[EXP_W+MAN_W-1:MAN_W];
  assign reserved = (expo == '0) || (expo == '1);
  // Q_INT integer bits, hidden one in the units place, fraction below.
  assign sig      = {{(Q_INT-1){1'b0}}, 1'b1, op[MAN_W-1:0], {PAD{1'b0}}};
endmodule

// File: rtl/fmul_signorm.sv
module fmul_signorm #(
  parameter int SIG_W = fmul_pkg::FMT_SIG_W,
  parameter int Q_INT = fmul_pkg::FMT_Q_INT,
  localparam int IDX_W = $clog2(SIG_W)
) (
  input  logic [SIG_W-1:0]        sig_a,
  input  logic [SIG_W-1:0]        sig_b,
  output logic [SIG_W-1:0]        norm,
  output logic signed [IDX_W:0]   adj
);
  localparam int PW = 2 * SIG_W;
  localparam int FB = SIG_W - Q_INT;

  logic [PW-1:0]    prod;
  logic [SIG_W-1:0] hi;
  logic [IDX_W-1:0] msb;

  assign prod = PW'(sig_a) * PW'(sig_b);
  // Lower product word collapses into one sticky bit at the LSB.
  assign hi   = prod[PW-1:SIG_W] | {{(SIG_W-1){1'b0}}, |prod[SIG_W-1:0]};

  always_comb begin
    msb = '0;
    for (int i = 0; i < SIG_W; i++) begin
      if (hi[i]) msb = IDX_W'(i);
    end
  end

  // Leading one never sits above the units bit, so the shift is leftward and exact.
  assign norm = hi << (IDX_W'(FB) - msb);
  assign adj  = $signed({1'b0, msb}) - $signed((IDX_W+1)'(FB));
endmodule

// File: rtl/fmul_pack.sv
module fmul_pack
  import fmul_pkg::*;
#(
  parameter int EXP_W  = FMT_EXP_W,
  parameter int MAN_W  = FMT_MAN_W,
  parameter int SIG_W  = FMT_SIG_W,
  parameter int Q_INT  = FMT_Q_INT,
  parameter int EXP_IW = FMT_EXP_W + 3
) (
  input  logic                     sign,
  input  logic                     reserved,
  input  logic signed [EXP_IW-1:0] exp_pre,
  input  logic [SIG_W-1:0]         norm,
  output logic [EXP_W+MAN_W:0]     result,
  output res_class_e               rclass
);
  localparam int FB      = SIG_W - Q_INT;
  localparam int GRD     = FB - 1 - MAN_W;
  localparam int EXP_TOP = (1 << EXP_W) - 1;

  logic [MAN_W-1:0]         man;
  logic                     guard, rest, up, carry;
  logic [MAN_W-1:0]         man_r;
  logic signed [EXP_IW-1:0] exp_r;

  assign man   = norm[FB-1 -: MAN_W];
  assign guard = norm[GRD];
  assign rest  = |norm[GRD-1:0];
  assign up    = guard & (rest | man[0]);
  assign {carry, man_r} = {1'b0, man} + (MAN_W+1)'(up);
  assign exp_r = exp_pre + EXP_IW'(carry);

  always_comb begin
    if (reserved) begin
      rclass = RC_SPECIAL;
      result = '0;
    end else if (exp_r >= $signed(EXP_IW'(EXP_TOP))) begin
      rclass = RC_OVF;
      result = {sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    end else if (exp_r <= $signed(EXP_IW'(0))) begin
      rclass = RC_UNF;
      result = {sign, {(EXP_W+MAN_W){1'b0}}};
    end else begin
      rclass = RC_NORMAL;
      result = {sign, exp_r[EXP_W-1:0], man_r};
    end
  end
endmodule

// File: rtl/fmul_sp32.sv
module fmul_sp32
  import fmul_pkg::*;
#(
  parameter int EXP_W = FMT_EXP_W,
  parameter int MAN_W = FMT_MAN_W,
  parameter int SIG_W = FMT_SIG_W,
  parameter int Q_INT = FMT_Q_INT,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result,
  output logic              out_special
);
  localparam int EXP_IW = EXP_W + 3;
  localparam int IDX_W  = $clog2(SIG_W);
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_OFS = Q_INT - BIAS;

  logic [WORD_W-1:0] ops  [2];
  logic              sgn  [2];
  logic [EXP_W-1:0]  expo [2];
  logic [SIG_W-1:0]  sig  [2];
  logic              rsv  [2];

  assign ops[0] = in_a;
  assign ops[1] = in_b;

  for (genvar gi = 0; gi < 2; gi++) begin : g_op
    fmul_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .SIG_W(SIG_W), .Q_INT(Q_INT)) u_unp (
      .op(ops[gi]), .sign(sgn[gi]), .expo(expo[gi]), .sig(sig[gi]), .reserved(rsv[gi])
    );
  end

  logic [SIG_W-1:0]         norm;
  logic signed [IDX_W:0]    adj;
  logic signed [EXP_IW-1:0] exp_pre;
  logic [WORD_W-1:0]        packed_res;
  res_class_e               rclass;

  fmul_signorm #(.SIG_W(SIG_W), .Q_INT(Q_INT)) u_mul (
    .sig_a(sig[0]), .sig_b(sig[1]), .norm(norm), .adj(adj)
  );

  assign exp_pre = $signed(EXP_IW'(expo[0])) + $signed(EXP_IW'(expo[1]))
                 + EXP_IW'(adj) + EXP_IW'(EXP_OFS);

  fmul_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .SIG_W(SIG_W), .Q_INT(Q_INT),
              .EXP_IW(EXP_IW)) u_pack (
    .sign(sgn[0] ^ sgn[1]), .reserved(rsv[0] | rsv[1]), .exp_pre(exp_pre),
    .norm(norm), .result(packed_res), .rclass(rclass)
  );

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_special <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid   <= 1'b1;
      out_result  <= packed_res;
      out_special <= (rclass == RC_SPECIAL);
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/fmul_sp32_chk.sv
module fmul_sp32_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_a,
  input logic [WORD_W-1:0] in_b,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_result,
  input logic              out_special
);
  logic fire;
  assign fire = in_valid & in_ready;

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_special));

  p_fire_r8: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);

  p_sign_r2: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_special || (out_result[WORD_W-1] == $past(in_a[WORD_W-1] ^ in_b[WORD_W-1])));

  p_zero_exp_r1: assert property (@(posedge clk) disable iff (rst)
    fire && (in_a[WORD_W-2:MAN_W] == '0) |=> out_special && (out_result == '0));

  p_no_nan_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_special |-> !((out_result[WORD_W-2:MAN_W] == '1) && (out_result[MAN_W-1:0] != '0)));

  p_reset_r10: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

bind fmul_sp32 fmul_sp32_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a),
  .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_special(out_special)
);

// File: tb/sim_fmul_sp32.sv
`timescale 1ns/1ps
module sim_fmul_sp32;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_special;

  int total = 0;
  int bad = 0;
  bit bp_en = 1'b0;
  bit done = 1'b0;

  logic [31:0] q_res[$];
  bit          q_spc[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  fmul_sp32 u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_special(out_special)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Independent reference: 24x24 integer significand product, then round.
  task automatic model(input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output bit s);
    int e;
    logic [47:0] p;
    logic [22:0] m;
    logic [23:0] m1;
    bit g, st, sg;
    sg = a[31] ^ b[31];
    if (a[30:23] == 8'd0 || a[30:23] == 8'hFF || b[30:23] == 8'd0 || b[30:23] == 8'hFF) begin
      s = 1'b1; r = '0; return;
    end
    s = 1'b0;
    p = {24'd0, 1'b1, a[22:0]} * {24'd0, 1'b1, b[22:0]};
    e = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (p[47]) begin
      m = p[46:24]; g = p[23]; st = |p[22:0]; e++;
    end else begin
      m = p[45:23]; g = p[22]; st = |p[21:0];
    end
    m1 = {1'b0, m} + 24'(g && (st || m[0]));
    if (m1[23]) e++;
    if (e >= 255)     r = {sg, 8'hFF, 23'd0};
    else if (e <= 0)  r = {sg, 31'd0};
    else              r = {sg, 8'(e), m1[22:0]};
  endtask

  task automatic drive(logic [31:0] a, logic [31:0] b, logic [31:0] er, bit es, string tag);
    q_res.push_back(er); q_spc.push_back(es); q_tag.push_back(tag);
    @(posedge clk); #1;
    in_valid = 1'b1; in_a = a; in_b = b;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drive_m(logic [31:0] a, logic [31:0] b, string tag);
    logic [31:0] r; bit s;
    model(a, b, r, s);
    drive(a, b, r, s, tag);
  endtask

  always begin
    @(posedge clk); #1;
    out_ready = bp_en ? ($urandom % 4 != 0) : 1'b1;
  end

  // Monitor / scoreboard
  bit          hold_pend = 1'b0;
  logic [31:0] held_r;
  bit          held_s;
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend && out_valid)
        chk(out_result == held_r && out_special == held_s, "R9 hold", out_result, held_r);
      hold_pend = 1'b0;
      if (out_valid && !out_ready) begin
        chk(in_ready == 1'b0, "R8 ready-full", 32'(in_ready), 32'd0);
        hold_pend = 1'b1; held_r = out_result; held_s = out_special;
      end
      if (!out_valid)
        chk(in_ready == 1'b1, "R8 ready-empty", 32'(in_ready), 32'd1);
      if (out_valid && out_ready) begin
        if (q_res.size() == 0) begin
          chk(1'b0, "R8 unexpected result", out_result, 32'd0);
        end else begin
          logic [31:0] er; bit es; string tg;
          er = q_res.pop_front(); es = q_spc.pop_front(); tg = q_tag.pop_front();
          chk(out_result == er && out_special == es, tg, out_result, er);
        end
      end
    end
  end

  function automatic logic [31:0] rand_op();
    logic [7:0] e;
    case ($urandom % 16)
      0:       e = 8'(1 + $urandom % 8);
      1:       e = 8'(247 + $urandom % 8);
      2:       e = ($urandom % 2) ? 8'd0 : 8'hFF;
      default: e = 8'(64 + $urandom % 128);
    endcase
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 reset valid", 32'(out_valid), 32'd0);
    #1 rst = 1'b0;

    drive(32'h3F800000, 32'h3F800000, 32'h3F800000, 0, "R3 one*one");
    drive(32'h40000000, 32'h40400000, 32'h40C00000, 0, "R3 2*3");
    drive(32'h3FC00000, 32'h3FC00000, 32'h40100000, 0, "R3 1.5*1.5");
    drive(32'hC0000000, 32'h40400000, 32'hC0C00000, 0, "R2 -2*3");
    drive(32'h3F800001, 32'h3FC00000, 32'h3FC00002, 0, "R4 tie odd up");
    drive(32'h3F800003, 32'h3FC00000, 32'h3FC00004, 0, "R4 tie even stay");
    drive(32'h3FFFFFFE, 32'h3F800001, 32'h40000000, 0, "R5 round carry");
    drive(32'h3F800001, 32'h3FC00001, 32'h3FC00003, 0, "R11 deep sticky");
    drive(32'h7F000000, 32'h40000000, 32'h7F800000, 0, "R6 overflow");
    drive(32'hFF000000, 32'h40000000, 32'hFF800000, 0, "R6 R2 neg overflow");
    drive(32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 0, "R6 max finite");
    drive(32'h00800000, 32'h3F000000, 32'h00000000, 0, "R7 underflow");
    drive(32'h80800000, 32'h3F000000, 32'h80000000, 0, "R7 R2 neg underflow");
    drive(32'h00800000, 32'h3F800000, 32'h00800000, 0, "R7 min normal kept");
    drive(32'h00000000, 32'h3F800000, 32'h00000000, 1, "R1 zero operand");
    drive(32'h3F800000, 32'h7F800000, 32'h00000000, 1, "R1 inf operand");
    drive(32'h7FC00000, 32'hBF800000, 32'h00000000, 1, "R1 nan operand");
    drive(32'h3F800000, 32'h00000001, 32'h00000000, 1, "R1 subnormal operand");

    bp_en = 1'b1;
    for (int i = 0; i < 3000; i++) drive_m(rand_op(), rand_op(), "R3 R8 random");

    for (int i = 0; i < 2000 && q_res.size() != 0; i++) @(posedge clk);
    chk(q_res.size() == 0, "R8 all results seen", 32'(q_res.size()), 32'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule